// File: doc/BRIEF.md
# Four-Mode Reload Timer with Pin

This block is a down-counting reload timer built from two stages. The first stage is a prescaler and the second is the main timer. Each stage has its own reload latch and divides by one more than its latch value. Every prescaler underflow advances the main timer by one. Every main-timer underflow raises a one-cycle interrupt pulse, and the timer then reloads and keeps counting.

One external pin works with the timer, and the operating mode sets its role:
- **Free-running timer:** the pin has no role in counting.
- **Toggling output:** the block drives the pin and flips it at each underflow.
- **Edge counter:** the pin is the count source.
- **Gated width measurement:** the pin gates the internal count source.

A single polarity bit takes a different meaning in each mode: the starting output level, the counted edge, or the measured level. The internal count source is the system clock divided by one of two fixed ratios. A stop bit freezes counting in every mode.

Software reaches the block through a write strobe with a two-bit address and a read strobe with a one-bit select. The read returns the live count of the timer or of the prescaler.

Top module: `tmr_pin_unit`

## Requirements
- R1: With prescaler latch p and timer latch t, running in timer mode from the divide-by-2 source, successive timer interrupt pulses are exactly 2·(p+1)·(t+1) clock cycles apart.
- R2: Both stages count down by one per count pulse. A count pulse that finds a stage at 0 reloads it from its latch, and that reload is the stage's underflow. A timer read (rd_en with rd_sel=0) or a prescaler read (rd_sel=1) returns the count one cycle later on rd_data.
- R3: Each timer underflow produces a tmr_irq pulse exactly one cycle wide, registered on the edge of the underflow.
- R4: A control write (wr_addr=2) sets pin_oe to 1 only when the mode field wr_data[1:0] is 1 (toggling output). The same write sets pin_out to the inverse of the polarity bit wr_data[2]. In toggling-output mode, pin_out flips on every timer underflow. In any other mode, pin_out only changes on a control write.
- R5: In mode 2 (edge counter), the prescaler receives one count pulse per rising pin edge when the polarity bit is 0, and one per falling pin edge when it is 1.
- R6: In mode 3 (width measurement), the internal source is counted only while the synchronized pin is high (polarity 0) or low (polarity 1).
- R7: Control bit wr_data[3] chooses the internal count source: 0 gives one pulse every 2 clock cycles, 1 gives one pulse every 16 clock cycles. Mode 0 (timer) counts this source.
- R8: While the stop bit wr_data[4] of the control register is 1, neither counter changes, except through a latch write.
- R9: Every active pin edge, as selected by the polarity bit, produces a one-cycle pin_irq pulse in every mode, including when the timer is stopped.
- R10: A latch write goes to wr_addr=0 (prescaler) or wr_addr=1 (timer). While the timer is stopped, the write also loads the counter. While it runs, only the latch changes, and the next reload uses the new value. A reload that falls in the same cycle as the write still uses the previous latch value.
- R11: The pin passes through two synchronizing flip-flops. pin_irq rises on the third clock edge after the pin changes.
- R12: After reset, both latches and both counters hold 0xFF. The control register holds timer mode, polarity 0, the divide-by-2 source and stop=1. pin_out, pin_oe, tmr_irq, pin_irq and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 prescaler latch, 1 timer latch, 2 control, 3 unused |
| wr_data | input | W | Write data; control fields in bits 4:0 |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 timer count, 1 prescaler count |
| rd_data | output | W | Registered read data |
| pin_in | input | 1 | Asynchronous pin level |
| pin_out | output | 1 | Pin drive level |
| pin_oe | output | 1 | Pin drive enable |
| tmr_irq | output | 1 | Timer underflow pulse |
| pin_irq | output | 1 | Active pin edge pulse |

## Verification
Two functions can fall in the same cycle: a timer-latch write issued by software while the timer runs, and the automatic reload at underflow. The bench restarts the timer from a known state and delays the latch write by each offset across a full timer period, so at least one offset lands the write on the reload edge. A reference model that knows nothing of the RTL's structure judges every cycle. It predicts that the reload in that cycle takes the old latch value and that the next reload takes the new one.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_WIDTH = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      stop;
    logic      src_slow;
    logic      pol;
    tmr_mode_e mode;
  } tmr_ctl_t;

  localparam int CTL_BITS = $bits(tmr_ctl_t);

  localparam logic [1:0] ADDR_PRE = 2'd0;
  localparam logic [1:0] ADDR_TMR = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
endpackage

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer with edge detection on the settled level.
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh[0] <= 1'b0;
          else     sh[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh[i] <= 1'b0;
          else     sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sh[STAGES-1];
  end

  assign lvl  = sh[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/tmr_src_div.sv
`timescale 1ns/1ps
// Free-running divider giving a fast and a slow count-source tick.
module tmr_src_div #(
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_slow,
  output logic tick
);
  localparam int DIVW = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;
  localparam logic [DIVW-1:0] LAST_HI = DIVW'(DIV_HI - 1);
  localparam logic [DIVW-1:0] MASK_LO = DIVW'(DIV_LO - 1);

  logic [DIVW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst)                     div_cnt <= '0;
    else if (div_cnt == LAST_HI) div_cnt <= '0;
    else                         div_cnt <= div_cnt + 1'b1;
  end

  assign tick = sel_slow ? (div_cnt == LAST_HI)
                         : ((div_cnt & MASK_LO) == MASK_LO);
endmodule

// File: rtl/tmr_reload_cnt.sv
`timescale 1ns/1ps
// One down-counting stage with its reload latch.
module tmr_reload_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic         load_now,
  output logic [W-1:0] cnt,
  output logic [W-1:0] lat,
  output logic         uf
);
  assign uf = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
      lat <= '1;
    end else begin
      if (step) cnt <= (cnt == '0) ? lat : cnt - 1'b1;
      if (wr) begin
        lat <= wr_val;
        if (load_now) cnt <= wr_val;
      end
    end
  end
endmodule

// File: rtl/tmr_pin_unit.sv
`timescale 1ns/1ps
module tmr_pin_unit
  import tmr_pkg::*;
#(
  parameter int W           = 8,
  parameter int DIV_LO      = 2,
  parameter int DIV_HI      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         pin_in,
  output logic         pin_out,
  output logic         pin_oe,
  output logic         tmr_irq,
  output logic         pin_irq
);
  tmr_ctl_t     ctl;
  logic         pin_lvl, pin_rise, pin_fall;
  logic         tick, edge_act, raw_pulse, cnt_pulse;
  logic         pre_uf, tmr_uf;
  logic [W-1:0] pre_cnt, tmr_cnt, pre_lat, tmr_lat;
  logic         wr_pre, wr_tmr, wr_ctl;

  assign wr_pre = wr_en && (wr_addr == ADDR_PRE);
  assign wr_tmr = wr_en && (wr_addr == ADDR_TMR);
  assign wr_ctl = wr_en && (wr_addr == ADDR_CTL);

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(pin_in),
    .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  tmr_src_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
    .clk(clk), .rst(rst), .sel_slow(ctl.src_slow), .tick(tick)
  );

  assign edge_act = ctl.pol ? pin_fall : pin_rise;

  always_comb begin
    case (ctl.mode)
      MODE_EVENT: raw_pulse = edge_act;
      MODE_WIDTH: raw_pulse = tick && (pin_lvl != ctl.pol);
      default:    raw_pulse = tick;
    endcase
    cnt_pulse = raw_pulse && !ctl.stop;
  end

  tmr_reload_cnt #(.W(W)) u_pre (
    .clk(clk), .rst(rst), .step(cnt_pulse), .wr(wr_pre), .wr_val(wr_data),
    .load_now(ctl.stop), .cnt(pre_cnt), .lat(pre_lat), .uf(pre_uf)
  );

  tmr_reload_cnt #(.W(W)) u_tmr (
    .clk(clk), .rst(rst), .step(pre_uf), .wr(wr_tmr), .wr_val(wr_data),
    .load_now(ctl.stop), .cnt(tmr_cnt), .lat(tmr_lat), .uf(tmr_uf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '{stop: 1'b1, src_slow: 1'b0, pol: 1'b0, mode: MODE_TIMER};
      pin_oe  <= 1'b0;
      pin_out <= 1'b0;
      tmr_irq <= 1'b0;
      pin_irq <= 1'b0;
      rd_data <= '0;
    end else begin
      tmr_irq <= tmr_uf;
      pin_irq <= edge_act;
      if (wr_ctl) begin
        ctl     <= tmr_ctl_t'(wr_data[CTL_BITS-1:0]);
        pin_oe  <= (tmr_mode_e'(wr_data[1:0]) == MODE_PULSE);
        pin_out <= ~wr_data[2];
      end else if (ctl.mode == MODE_PULSE && tmr_uf) begin
        pin_out <= ~pin_out;
      end
      if (rd_en) rd_data <= rd_sel ? pre_cnt : tmr_cnt;
    end
  end
endmodule

// File: rtl/tmr_pin_unit_chk.sv
`timescale 1ns/1ps
module tmr_pin_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic         stop,
  input logic [W-1:0] tmr_cnt,
  input logic [W-1:0] pre_cnt,
  input logic [W-1:0] tmr_lat,
  input logic [W-1:0] pre_lat,
  input logic         pin_out,
  input logic         pin_oe,
  input logic         tmr_irq,
  input logic         pin_irq
);
  assert_reload_value_R2: assert property (@(posedge clk) disable iff (rst)
    tmr_irq |-> (tmr_cnt == $past(tmr_lat)));

  assert_irq_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    tmr_irq |=> !tmr_irq);

  assert_pin_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!pin_oe && !(wr_en && wr_addr == 2'd2)) |=> $stable(pin_out));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (stop && !(wr_en && wr_addr[1] == 1'b0)) |=> ($stable(tmr_cnt) && $stable(pre_cnt)));

  assert_pin_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    pin_irq |=> !pin_irq);

  assert_stopped_load_R10: assert property (@(posedge clk) disable iff (rst)
    (stop && wr_en && wr_addr == 2'd0) |=> (pre_cnt == pre_lat));
endmodule

bind tmr_pin_unit tmr_pin_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .stop(ctl.stop),
  .tmr_cnt(tmr_cnt), .pre_cnt(pre_cnt), .tmr_lat(tmr_lat), .pre_lat(pre_lat),
  .pin_out(pin_out), .pin_oe(pin_oe), .tmr_irq(tmr_irq), .pin_irq(pin_irq)
);

// File: tb/sim_tmr_pin_unit.sv
`timescale 1ns/1ps
module sim_tmr_pin_unit;
  localparam int W = 8;

  logic         clk = 1'b0, rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0, rd_sel = 1'b0, pin_in = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         pin_out, pin_oe, tmr_irq, pin_irq;

  always #2 clk = ~clk;

  tmr_pin_unit u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .tmr_irq(tmr_irq), .pin_irq(pin_irq)
  );

  int checks = 0, errors = 0, pi_cnt = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated at each rising edge.
  int m_ok = 0, m_div, m_s1, m_s2, m_s3, m_pre, m_tmr, m_prel, m_tmrl;
  int m_mode, m_pol, m_src, m_stop, m_out, m_oe, m_ti, m_pi, m_rd;
  int tk, rise, fall, act, cp, puf, tuf, n_pre, n_tmr, n_out;

  always @(posedge clk) begin
    if (rst) begin
      m_ok = 1; m_div = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_pre = 255; m_tmr = 255; m_prel = 255; m_tmrl = 255;
      m_mode = 0; m_pol = 0; m_src = 0; m_stop = 1;
      m_out = 0; m_oe = 0; m_ti = 0; m_pi = 0; m_rd = 0;
    end else begin
      tk   = m_src ? int'(m_div == 15) : int'(m_div % 2 == 1);
      rise = int'(m_s2 == 1 && m_s3 == 0);
      fall = int'(m_s2 == 0 && m_s3 == 1);
      act  = m_pol ? fall : rise;
      case (m_mode)
        2:       cp = act;
        3:       cp = int'(tk == 1 && m_s2 != m_pol);
        default: cp = tk;
      endcase
      if (m_stop == 1) cp = 0;
      puf   = int'(cp == 1 && m_pre == 0);
      tuf   = int'(puf == 1 && m_tmr == 0);
      n_pre = (cp == 1)  ? ((m_pre == 0) ? m_prel : m_pre - 1) : m_pre;
      n_tmr = (puf == 1) ? ((m_tmr == 0) ? m_tmrl : m_tmr - 1) : m_tmr;
      n_out = m_out;
      if (rd_en) m_rd = rd_sel ? m_pre : m_tmr;
      if (wr_en && wr_addr == 2) n_out = 1 - int'(wr_data[2]);
      else if (m_mode == 1 && tuf == 1) n_out = 1 - m_out;
      if (wr_en && wr_addr == 0) begin
        m_prel = int'(wr_data);
        if (m_stop == 1) n_pre = int'(wr_data);
      end
      if (wr_en && wr_addr == 1) begin
        m_tmrl = int'(wr_data);
        if (m_stop == 1) n_tmr = int'(wr_data);
      end
      if (wr_en && wr_addr == 2) begin
        m_mode = int'(wr_data[1:0]); m_pol = int'(wr_data[2]);
        m_src  = int'(wr_data[3]);   m_stop = int'(wr_data[4]);
        m_oe   = int'(wr_data[1:0] == 2'd1);
      end
      m_pre = n_pre; m_tmr = n_tmr; m_out = n_out;
      m_ti = tuf; m_pi = act;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(pin_in);
      m_div = (m_div + 1) % 16;
    end
  end

  always @(negedge clk) begin
    if (m_ok == 1 && !rst) begin
      check("R2 rd_data", int'(rd_data), m_rd);
      check("R3 tmr_irq", int'(tmr_irq), m_ti);
      check("R4 pin_out", int'(pin_out), m_out);
      check("R4 pin_oe", int'(pin_oe), m_oe);
      check("R9 pin_irq", int'(pin_irq), m_pi);
    end
    if (pin_irq) pi_cnt++;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int sel, output int v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel[0];
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic wait_ti(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tmr_irq && n < 5000);
  endtask

  task automatic pulse(int hi, int lo);
    pin_in = 1'b1; cyc(hi);
    pin_in = 1'b0; cyc(lo);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, v2, a, b, n;
    cyc(3);
    rst = 1'b0;
    // R12 reset state
    rd(0, v); check("R12 timer count after reset", v, 255);
    rd(1, v); check("R12 prescaler count after reset", v, 255);
    check("R12 pin_oe after reset", int'(pin_oe), 0);
    check("R12 tmr_irq after reset", int'(tmr_irq), 0);

    // R10 stopped write loads the counter
    wr(0, 1); wr(1, 3);
    rd(0, v); check("R10 stopped latch write loads timer", v, 3);

    // R1 period in timer mode, fast source
    wr(2, 8'h00);
    wait_ti(a); wait_ti(b);
    check("R1 underflow period p=1 t=3", b, 16);

    // R10 running write only changes the latch
    wr(1, 8'h20);
    rd(0, v); check("R10 running write leaves count", int'(v <= 3), 1);
    wait_ti(a); wait_ti(b);
    check("R10 new latch used after next reload", b, 132);
    wr(1, 3);
    wait_ti(a);

    // R7 slow source
    wr(2, 8'h08);
    wait_ti(a); wait_ti(b);
    check("R7 period with divide-by-16 source", b, 128);

    // R4 toggling output, polarity 1 then 0
    wr(2, 8'h05);
    check("R4 start level polarity 1", int'(pin_out), 0);
    check("R4 enable in toggle mode", int'(pin_oe), 1);
    wait_ti(a); check("R4 first toggle", int'(pin_out), 1);
    wait_ti(a); check("R4 second toggle", int'(pin_out), 0);
    wr(2, 8'h01);
    check("R4 start level polarity 0", int'(pin_out), 1);

    // R5 edge counter, rising edges
    wr(2, 8'h10); wr(0, 0); wr(1, 5); wr(2, 8'h02);
    pi_cnt = 0;
    for (int i = 0; i < 3; i++) pulse(4, 4);
    cyc(5);
    rd(0, v); check("R5 three rising edges counted", v, 2);
    check("R9 one pin_irq per rising edge", pi_cnt, 3);
    wr(2, 8'h06);
    pulse(4, 4); cyc(5);
    rd(0, v); check("R5 only falling edge counted", v, 1);

    // R6 width measurement, high level counted
    wr(2, 8'h13); wr(1, 8'hFF); wr(2, 8'h03);
    cyc(40);
    rd(0, v); check("R6 no count while pin low", v, 255);
    pulse(20, 6);
    rd(0, v); check("R6 count while pin high", int'(v < 255), 1);

    // R8 stop freezes counting
    wr(2, 8'h00); cyc(10); wr(2, 8'h10);
    rd(0, v); cyc(30); rd(0, v2);
    check("R8 counter frozen while stopped", v2, v);

    // R11 synchronizer latency, R9 edge seen while stopped
    pin_in = 1'b0; cyc(5);
    @(negedge clk); pin_in = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pin_irq && n < 10);
    check("R11 pin_irq on third edge", n, 3);
    pin_in = 1'b0; cyc(4);

    // R10 latch write swept across the reload edge
    for (int off = 0; off < 12; off++) begin
      wr(2, 8'h10); wr(0, 0); wr(1, 3); wr(2, 8'h00);
      cyc(off);
      wr(1, 2);
      cyc(30);
    end

    cyc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule